// File: doc/BRIEF.md
# Two-Wire Handshaked Serial Command Master

This block is the host side of a two-wire serial link to a target that executes commands. The host always drives the clock line. The data line is shared: the host drives it while it sends a command and releases it afterwards. A command is one or more 16-bit words, taken from a valid/ready word port. The word that carries the last-word flag also carries the response length in words. The host shifts every word out most significant bit first. It changes data only while the clock is low, so the target samples it on the rising edge.

After the last word the host releases the data line and stops the clock. The target first raises the line to show that it is busy, then pulls it low to show that a response is ready. The host then issues exactly 16 clock pulses per response word. The target changes data after each falling edge, and the host samples it at the end of each low phase, which is the instant of the next rising edge. Each received word appears for one cycle on a valid strobe. A one-cycle done pulse ends every command. If the target does not go high, or does not go low, within a set number of cycles, the host abandons the command and raises an error flag. The clock half period and the minimum gap between commands are derived from the system clock frequency.

Top module: `sercmd_host`

## Requirements
- R1: Each command word is sent as exactly 16 rising clock edges with the data bits ordered from bit 15 down to bit 0. Words are accepted one after another until the word with `cmd_last`=1, and that word's `cmd_rsp_len` is captured as the response length.
- R2: While the host drives the data line, `link_dout` changes only while `link_clk` is low; it is stable throughout every high phase.
- R3: The host drops `link_oe` at the falling clock edge that ends bit 0 of the last command word, and leaves it low until the next command is accepted.
- R4: From the release until the host sees the target pull the line low, `link_clk` stays low with no edges.
- R5: After the ready-low indication, the host issues exactly 16×`cmd_rsp_len` rising edges. It samples `link_din` at the end of each low phase, and builds each response word from bit 15 down to bit 0. Each word is presented on `rsp_word` with `rsp_valid` high for one cycle.
- R6: After reset and whenever `busy` is low, `link_clk` and `link_oe` are 0, `done` and `err` are 0 after reset, and `cmd_ready` is 1 after reset.
- R7: Every high phase of `link_clk` lasts HALF = ceil(CLK_HZ / (2·SCK_HZ)) system clock cycles.
- R8: After `done`, `cmd_ready` stays low for exactly GAP = CLK_HZ / GAP_DIV cycles, and then rises.
- R9: If the synchronized line is not seen high within WAIT_HI_CYC cycles of the release, the host stops. `done` and `err` rise WAIT_HI_CYC+1 cycles after `link_oe` falls, and no response word is produced.
- R10: If the line goes high but is not seen low within WAIT_LO_CYC cycles, the host stops with `done` and `err` set, and no response word is produced.
- R11: `done` is a one-cycle pulse at the end of every command, and `err` stays set until the first word of the next command is accepted.
- R12: A response length of 0 ends the command as soon as the ready-low indication is seen, with no clock pulses after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Host takes the offered word this cycle |
| cmd_word | input | 16 | Command word |
| cmd_last | input | 1 | Word is the last of its command |
| cmd_rsp_len | input | LEN_W | Response length in words, valid with the last word |
| rsp_valid | output | 1 | One-cycle strobe for a received word |
| rsp_word | output | 16 | Received response word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| err | output | 1 | Last command ended by a handshake timeout |
| link_clk | output | 1 | Serial clock, idle low |
| link_dout | output | 1 | Data driven towards the target |
| link_oe | output | 1 | Enable for the data line driver |
| link_din | input | 1 | Data line as seen by the host |

## Verification
The assertions assume that the command inputs stay steady until they are accepted. They also assume that the target's busy level lasts at least one system clock. Response bits are assumed to settle within two cycles of a falling edge, which needs a half period of at least three cycles, because the line passes through a two-stage synchronizer. The bench target follows these rules: it uses a half period of four cycles, holds the busy level for several cycles, and changes response bits only right after the falling clock edges it observes.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int WORD_W = 16;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_LO,
    ST_TX_HI,
    ST_NEXT,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_RX_HI,
    ST_RX_LO
  } st_e;
endpackage

// File: rtl/sercmd_phase.sv
// Half-period tick generator for the serial clock.
module sercmd_phase #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sercmd_dcnt.sv
// Loadable down counter that stops at zero.
module sercmd_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= val;
    else if (!zero) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sercmd_shift.sv
// Word shifter, most significant bit leaves first, new bits enter at bit 0.
module sercmd_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/sercmd_host.sv
module sercmd_host
  import sercmd_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SCK_HZ      = 1_850_000,
  parameter int GAP_DIV     = 40,
  parameter int WAIT_HI_CYC = 1_000,
  parameter int WAIT_LO_CYC = 5_000_000,
  parameter int LEN_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_word,
  input  logic              cmd_last,
  input  logic [LEN_W-1:0]  cmd_rsp_len,
  output logic              rsp_valid,
  output logic [15:0]       rsp_word,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              link_clk,
  output logic              link_dout,
  output logic              link_oe,
  input  logic              link_din
);
  localparam int HALF    = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);
  localparam int GAP_CYC = CLK_HZ / GAP_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int TMO_MAX = (WAIT_HI_CYC > WAIT_LO_CYC) ? WAIT_HI_CYC : WAIT_LO_CYC;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  st_e               state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  word_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_q;
  logic              sck_q;
  logic              oe_q;
  logic              done_q;
  logic              err_q;
  logic              rv_q;
  logic [15:0]       rw_q;
  logic              sd_m_q;
  logic              sd_s_q;

  logic              tick;
  logic              run;
  logic              accept;
  logic              gap_zero;
  logic              tmo_zero;
  logic              tmo_ld;
  logic [TMO_W-1:0]  tmo_val;
  logic              sh_en;
  logic [15:0]       sh_q;
  logic              tx_end;
  logic              rx_word_end;
  logic              rx_all_end;
  logic              tmo_hit;
  logic              finish;

  // two-stage synchronizer for the shared data line
  always_ff @(posedge clk) begin
    if (rst) begin
      sd_m_q <= 1'b0;
      sd_s_q <= 1'b0;
    end else begin
      sd_m_q <= link_din;
      sd_s_q <= sd_m_q;
    end
  end

  assign run = (state_q == ST_TX_LO) || (state_q == ST_TX_HI) ||
               (state_q == ST_RX_HI) || (state_q == ST_RX_LO);

  assign cmd_ready = ((state_q == ST_IDLE) && gap_zero) || (state_q == ST_NEXT);
  assign accept    = cmd_valid && cmd_ready;

  assign tx_end      = (state_q == ST_TX_HI) && tick && (bit_q == LAST_BIT);
  assign rx_word_end = (state_q == ST_RX_LO) && tick && (bit_q == LAST_BIT);
  assign rx_all_end  = rx_word_end && (word_q == len_q - LEN_W'(1));

  assign tmo_hit = ((state_q == ST_WAIT_HI) && !sd_s_q && tmo_zero) ||
                   ((state_q == ST_WAIT_LO) &&  sd_s_q && tmo_zero);
  assign finish  = tmo_hit || rx_all_end ||
                   ((state_q == ST_WAIT_LO) && !sd_s_q && (len_q == '0));

  assign tmo_ld  = (tx_end && last_q) || ((state_q == ST_WAIT_HI) && sd_s_q);
  assign tmo_val = (state_q == ST_TX_HI) ? TMO_W'(WAIT_HI_CYC) : TMO_W'(WAIT_LO_CYC);

  assign sh_en = tick && (((state_q == ST_TX_HI) && (bit_q != LAST_BIT)) ||
                          (state_q == ST_RX_LO));

  sercmd_phase #(.HALF(HALF)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  sercmd_shift #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .din   (cmd_word),
    .shift (sh_en),
    .sin   (sd_s_q),
    .q     (sh_q)
  );

  sercmd_dcnt #(.W(TMO_W)) u_tmo (
    .clk  (clk),
    .rst  (rst),
    .load (tmo_ld),
    .val  (tmo_val),
    .zero (tmo_zero)
  );

  sercmd_dcnt #(.W(GAP_W)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (finish),
    .val  (GAP_W'(GAP_CYC)),
    .zero (gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      len_q   <= '0;
      last_q  <= 1'b0;
      sck_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rv_q    <= 1'b0;
      rw_q    <= '0;
    end else begin
      done_q <= finish;
      rv_q   <= rx_word_end;
      if (rx_word_end) rw_q <= {sh_q[14:0], sd_s_q};
      if (tmo_hit) err_q <= 1'b1;

      if (accept) begin
        last_q <= cmd_last;
        if (cmd_last) len_q <= cmd_rsp_len;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_TX_LO;
            oe_q    <= 1'b1;
            sck_q   <= 1'b0;
            bit_q   <= '0;
            err_q   <= 1'b0;
          end
        end
        ST_TX_LO: begin
          if (tick) begin
            sck_q   <= 1'b1;
            state_q <= ST_TX_HI;
          end
        end
        ST_TX_HI: begin
          if (tick) begin
            sck_q <= 1'b0;
            bit_q <= bit_q + 1'b1;
            if (bit_q != LAST_BIT)   state_q <= ST_TX_LO;
            else if (last_q) begin
              oe_q    <= 1'b0;
              state_q <= ST_WAIT_HI;
            end else                 state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (accept) state_q <= ST_TX_LO;
        end
        ST_WAIT_HI: begin
          if (sd_s_q)        state_q <= ST_WAIT_LO;
          else if (tmo_zero) state_q <= ST_IDLE;
        end
        ST_WAIT_LO: begin
          if (!sd_s_q) begin
            if (len_q == '0) state_q <= ST_IDLE;
            else begin
              state_q <= ST_RX_HI;
              sck_q   <= 1'b1;
              bit_q   <= '0;
              word_q  <= '0;
            end
          end else if (tmo_zero) state_q <= ST_IDLE;
        end
        ST_RX_HI: begin
          if (tick) begin
            sck_q   <= 1'b0;
            state_q <= ST_RX_LO;
          end
        end
        ST_RX_LO: begin
          if (tick) begin
            bit_q <= bit_q + 1'b1;
            if (rx_all_end) state_q <= ST_IDLE;
            else begin
              if (rx_word_end) word_q <= word_q + 1'b1;
              sck_q   <= 1'b1;
              state_q <= ST_RX_HI;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rsp_valid = rv_q;
  assign rsp_word  = rw_q;
  assign link_clk  = sck_q;
  assign link_oe   = oe_q;
  assign link_dout = sh_q[15];
endmodule

// File: rtl/sercmd_host_chk.sv
module sercmd_host_chk
  import sercmd_pkg::*;
#(
  parameter int GAP_CYC = 20
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic link_clk,
  input logic link_oe,
  input logic link_dout,
  input logic done,
  input logic err,
  input logic cmd_ready,
  input logic rsp_valid,
  input st_e  st
);
  int since_done_q;

  always_ff @(posedge clk) begin
    if (rst)                        since_done_q <= GAP_CYC;
    else if (done)                  since_done_q <= 1;
    else if (since_done_q < GAP_CYC) since_done_q <= since_done_q + 1;
  end

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!link_clk && !link_oe)); // R6

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (link_clk && link_oe) |-> $stable(link_dout)); // R2

  AST_NO_CLK_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_HI || st == ST_WAIT_LO) |-> (!link_clk && !link_oe)); // R4

  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(link_oe) |-> (st == ST_WAIT_HI && $fell(link_clk))); // R3

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !busy) |-> (since_done_q >= GAP_CYC)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done); // R9

  AST_RSP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !link_oe); // R5

  AST_RISE_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(link_clk) |-> (st == ST_TX_HI || st == ST_RX_HI)); // R7
endmodule

bind sercmd_host sercmd_host_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .link_clk  (link_clk),
  .link_oe   (link_oe),
  .link_dout (link_dout),
  .done      (done),
  .err       (err),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .st        (state_q)
);

// File: tb/sercmd_host_tb.sv
`timescale 1ns/1ps
module sercmd_host_tb;
  localparam int CLK_HZ  = 800;
  localparam int SCK_HZ  = 100;
  localparam int GAP_DIV = 40;
  localparam int WHI     = 30;
  localparam int WLO     = 300;
  localparam int LEN_W   = 4;
  localparam int HALF    = 4;   // ceil(800 / 200)
  localparam int GAP     = 20;  // 800 / 40

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [15:0] cmd_word = '0;
  logic cmd_last = 1'b0;
  logic [LEN_W-1:0] cmd_rsp_len = '0;
  logic rsp_valid;
  logic [15:0] rsp_word;
  logic busy, done, err;
  logic link_clk, link_dout, link_oe;
  logic link_din = 1'b0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sercmd_host #(
    .CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .GAP_DIV(GAP_DIV),
    .WAIT_HI_CYC(WHI), .WAIT_LO_CYC(WLO), .LEN_W(LEN_W)
  ) u_dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .cmd_last(cmd_last), .cmd_rsp_len(cmd_rsp_len),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .busy(busy), .done(done), .err(err),
    .link_clk(link_clk), .link_dout(link_dout), .link_oe(link_oe),
    .link_din(link_din)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rsp(logic [15:0] c0, int k);
    return (c0 ^ 16'hC3A5) + 16'(k * 273);
  endfunction

  // mode: 0 normal, 1 target never goes high, 2 target never goes low
  task automatic run_cmd(int nw, int m, int hi_dly, int lo_dly,
                         logic [15:0] base, int mode);
    logic [15:0] cw [4];
    logic [15:0] got_cmd [4];
    logic [15:0] got_rsp [16];
    int nrsp = 0, tx_rise = 0, rx_rise = 0, wait_rise = 0;
    int hi_len = 0, hi_bad = 0, cyc = 0, t_rel = -1, t_done = 0;
    bit tgt_ready = 0, prev = 0, oe_prev = 0, err_after_acc = 0;
    cw[0] = base;
    for (int i = 1; i < 4; i++) cw[i] = {cw[i-1][10:0], cw[i-1][15:11]} ^ 16'h5A0F;
    for (int i = 0; i < 4; i++) got_cmd[i] = '0;
    fork
      begin : host_feed
        for (int i = 0; i < nw; i++) begin
          @(negedge clk);
          cmd_valid   = 1'b1;
          cmd_word    = cw[i];
          cmd_last    = (i == nw - 1);
          cmd_rsp_len = LEN_W'(m);
          while (!cmd_ready) @(negedge clk);
          @(negedge clk);
          if (i == 0) err_after_acc = err;
          cmd_valid = 1'b0;
        end
      end
      begin : target
        for (int b = 0; b < nw * 16; b++) begin
          @(posedge link_clk);
          got_cmd[b/16] = {got_cmd[b/16][14:0], link_dout};
        end
        @(negedge clk);
        while (link_oe) @(negedge clk);
        if (mode != 1) begin
          repeat (hi_dly) @(negedge clk);
          link_din = 1'b1;
          if (mode != 2) begin
            repeat (lo_dly) @(negedge clk);
            link_din  = 1'b0;
            tgt_ready = 1'b1;
            for (int b = 0; b < m * 16; b++) begin
              @(negedge link_clk);
              link_din = exp_rsp(cw[0], b / 16)[15 - (b % 16)];
            end
          end
        end
      end
      begin : monitor
        forever begin
          @(negedge clk);
          cyc++;
          if (link_clk && !prev) begin
            if (link_oe) tx_rise++;
            else if (!tgt_ready) wait_rise++;
            else rx_rise++;
          end
          if (link_clk) hi_len++;
          else begin
            if (prev && hi_len != HALF) hi_bad++;
            hi_len = 0;
          end
          if (oe_prev && !link_oe && t_rel < 0) t_rel = cyc;
          if (rsp_valid && nrsp < 16) begin
            got_rsp[nrsp] = rsp_word;
            nrsp++;
          end
          prev    = link_clk;
          oe_prev = link_oe;
          if (done) begin
            t_done = cyc;
            break;
          end
        end
      end
    join
    chk(tx_rise == nw * 16, "R1", "command rising edges", tx_rise, nw * 16);
    for (int i = 0; i < nw; i++)
      chk(got_cmd[i] == cw[i], "R1", "command word at target", got_cmd[i], cw[i]);
    chk(err_after_acc == 1'b0, "R11", "err cleared on accept", err_after_acc, 0);
    chk(wait_rise == 0, "R4", "clock edges during handshake", wait_rise, 0);
    chk(hi_bad == 0, "R7", "high phases not HALF long", hi_bad, 0);
    chk(t_rel > 0, "R3", "data line released", t_rel, 1);
    if (mode == 0) begin
      chk(err == 1'b0, "R5", "no error", err, 0);
      chk(nrsp == m, "R5", "response word count", nrsp, m);
      chk(rx_rise == 16 * m, m == 0 ? "R12" : "R5", "response rising edges", rx_rise, 16 * m);
      for (int k = 0; k < m && k < nrsp; k++)
        chk(got_rsp[k] == exp_rsp(cw[0], k), "R5", "response word", got_rsp[k], exp_rsp(cw[0], k));
    end else begin
      chk(err == 1'b1, mode == 1 ? "R9" : "R10", "error flag", err, 1);
      chk(nrsp == 0, mode == 1 ? "R9" : "R10", "no response on timeout", nrsp, 0);
      if (mode == 1)
        chk(t_done - t_rel == WHI + 1, "R9", "timeout latency", t_done - t_rel, WHI + 1);
    end
    link_din = 1'b0;
    begin
      int g = 0;
      @(negedge clk);
      g = 1;
      chk(done == 1'b0, "R11", "done one cycle", done, 0);
      while (!cmd_ready && g < 1000) begin
        @(negedge clk);
        g++;
      end
      chk(g == GAP, "R8", "gap before next command", g, GAP);
      chk(!busy && !link_clk && !link_oe, "R6", "idle lines", {busy, link_clk, link_oe}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !link_clk && !link_oe, "R6", "reset lines", {busy, link_clk, link_oe}, 0);
    chk(!done && !err && !rsp_valid, "R6", "reset status", {done, err, rsp_valid}, 0);
    chk(cmd_ready == 1'b1, "R6", "ready after reset", cmd_ready, 1);

    for (int nw = 1; nw <= 3; nw++)
      for (int m = 0; m <= 3; m++)
        run_cmd(nw, m, 1 + (nw + m) % 3, 3 + m,
                16'h8001 ^ 16'(nw * 16'h1F00) ^ 16'(m * 16'h00F3), 0);
    run_cmd(2, 2, 2, 4, 16'hFFFF, 0);
    run_cmd(2, 1, 3, 2, 16'h0000, 0);

    run_cmd(1, 2, 0, 0, 16'h1234, 1);   // R9
    run_cmd(2, 1, 2, 0, 16'hBEEF, 2);   // R10
    run_cmd(1, 1, 2, 3, 16'h7E81, 0);   // R11 error clears

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule